// File: doc/BRIEF.md
# Sequential Page Read Sequencer

This block is the device-side read engine of a byte-wide, read-only page memory. Each page holds 528 bytes. Columns 0 to 511 carry main data and columns 512 to 527 form a spare area. Thirty-two pages make up one block, and there are 1024 blocks. A command latch outside this block decodes the read command and the address cycles. It then pulses `start_i` with a mode, a start column and a page.

After the start pulse, the sequencer holds the ready/busy output low for a programmable load time. This models the array-to-register transfer. It then returns one byte for each read-enable pulse and advances the column after each byte. When a page ends, it moves into the next page of the same block, with a short wait and then another load time. It stops at the end of the block. If chip enable rises during that short wait, the next load is dropped and the read ends. The memory array sits outside the block as a synchronous ROM with one cycle of latency. The block drives the ROM address and turns the array byte into bus data with a bus drive enable.

Top module: `page_read_seq`

## Requirements
- R1: The start column depends on `mode_i`:
  - With `mode_i`=0 it is `start_col_i`.
  - With `mode_i`=1 it is 256+`start_col_i`.
  - With `mode_i[1]`=1 it is 512+`start_col_i[3:0]`.
- R2: After `start_i`, `rb_o` is low for exactly LOAD_CYCLES clock cycles and then returns high.
- R3: While streaming, `dq_o` holds the byte at the current column while `re_ni` is low. Each rising edge of `re_ni` advances the column by one.
- R4: After column 527 the page number increments. The column restarts at 0 in modes 0 and 1, and at 512 in spare mode, so spare mode streams only spare bytes.
- R5: Every byte read from columns 512 to 527 is 0xFF, whatever the array returns.
- R6: After column 527 of a page whose low five page bits are all ones, the sequencer goes idle. It produces no busy period and no further data.
- R7: After the last byte of a non-final page, `rb_o` goes low within GRACE_CYCLES+1 cycles and stays low for LOAD_CYCLES cycles.
- R8: A falling edge of `re_ni` while `ce_ni` is low and no data is being streamed raises `re_err_o` for one cycle. The column does not advance.
- R9: If `ce_ni` rises within the GRACE_CYCLES window after the last byte of a page, no busy period follows and the sequencer goes idle.
- R10: `ce_ni` high during load or streaming aborts the read and returns the sequencer to idle.
- R11: `dq_oe_o` is high only when all of the following hold:
  - `ce_ni` and `re_ni` are low.
  - `cle_i` and `ale_i` are low.
  - The sequencer is streaming.
- R12: After reset, `rb_o` is high and `dq_oe_o` and `re_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse from the command latch starting a read |
| mode_i | input | 2 | 0: lower main half, 1: upper main half, bit 1 set: spare area |
| start_col_i | input | 8 | Column offset within the selected area |
| start_page_i | input | 15 | Start page |
| ce_ni | input | 1 | Chip enable, active low |
| re_ni | input | 1 | Read enable, active low, one byte per pulse |
| cle_i | input | 1 | Command cycle indicator |
| ale_i | input | 1 | Address cycle indicator |
| rom_page_o | output | 15 | Array page address |
| rom_col_o | output | 10 | Array column address |
| rom_data_i | input | 8 | Array byte, valid one cycle after the address |
| dq_o | output | 8 | Read data onto the bus |
| dq_oe_o | output | 1 | Bus drive enable |
| rb_o | output | 1 | Ready (1) / busy (0), open-drain style |
| re_err_o | output | 1 | One-cycle flag for an illegal read-enable edge |

## Verification
The stream is exercised from low-half, high-half and spare start columns. These patterns separate the three start-column decodes. A run across the main-to-spare boundary shows the 0xFF forcing. Page crossings are taken in both a main mode and spare mode, which tells the column-0 wrap apart from the column-512 wrap. Busy is timed at both the start and each crossing. Directed runs then cover the following:
- Read pulses during busy.
- An early chip-enable rise at a page end.
- An abort in mid-stream.
- The stop at the end of a block.
- Gating of the drive enable by the command and address indicators.

// File: rtl/page_read_pkg.sv
package page_read_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_READY = 2'd2,
    ST_GRACE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/read_edge.sv
module read_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_ni;

  assign fall_o = strobe_q & ~strobe_ni;
  assign rise_o = ~strobe_q & strobe_ni;
endmodule

// File: rtl/load_timer.sv
module load_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/page_addr.sv
module page_addr #(
  parameter int PAGE_BYTES = 528,
  parameter int MAIN_BYTES = 512,
  parameter int BLK_PAGES  = 32,
  parameter int PAGE_W     = 15
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [1:0]                        mode_i,
  input  logic [$clog2(MAIN_BYTES)-2:0]     col_in_i,
  input  logic [PAGE_W-1:0]                 page_in_i,
  input  logic                              adv_i,
  output logic [$clog2(PAGE_BYTES)-1:0]     col_o,
  output logic [PAGE_W-1:0]                 page_o,
  output logic                              spare_o,
  output logic                              last_col_o,
  output logic                              last_in_blk_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int SP_W  = $clog2(PAGE_BYTES - MAIN_BYTES);
  localparam int BLK_W = $clog2(BLK_PAGES);

  logic [COL_W-1:0]  col_q, start_col;
  logic [PAGE_W-1:0] page_q;
  logic              spare_q;

  always_comb begin
    if (mode_i[1])      start_col = COL_W'(MAIN_BYTES) + COL_W'(col_in_i[SP_W-1:0]);
    else if (mode_i[0]) start_col = COL_W'(MAIN_BYTES / 2) + COL_W'(col_in_i);
    else                start_col = COL_W'(col_in_i);
  end

  assign last_col_o    = (col_q == COL_W'(PAGE_BYTES - 1));
  assign last_in_blk_o = &page_q[BLK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      page_q  <= '0;
      spare_q <= 1'b0;
    end else if (start_i) begin
      col_q   <= start_col;
      page_q  <= page_in_i;
      spare_q <= mode_i[1];
    end else if (adv_i) begin
      if (!last_col_o) begin
        col_q <= col_q + 1'b1;
      end else if (!last_in_blk_o) begin
        page_q <= page_q + 1'b1;
        col_q  <= spare_q ? COL_W'(MAIN_BYTES) : '0;
      end
    end
  end

  assign col_o   = col_q;
  assign page_o  = page_q;
  assign spare_o = spare_q;
endmodule

// File: rtl/page_read_seq.sv
module page_read_seq
  import page_read_pkg::*;
#(
  parameter int PAGE_BYTES   = 528,
  parameter int MAIN_BYTES   = 512,
  parameter int BLK_PAGES    = 32,
  parameter int PAGE_W       = 15,
  parameter int DATA_W       = 8,
  parameter int LOAD_CYCLES  = 8,
  parameter int GRACE_CYCLES = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [1:0]                    mode_i,
  input  logic [$clog2(MAIN_BYTES)-2:0] start_col_i,
  input  logic [PAGE_W-1:0]             start_page_i,
  input  logic                          ce_ni,
  input  logic                          re_ni,
  input  logic                          cle_i,
  input  logic                          ale_i,
  output logic [PAGE_W-1:0]             rom_page_o,
  output logic [$clog2(PAGE_BYTES)-1:0] rom_col_o,
  input  logic [DATA_W-1:0]             rom_data_i,
  output logic [DATA_W-1:0]             dq_o,
  output logic                          dq_oe_o,
  output logic                          rb_o,
  output logic                          re_err_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int TMR_MAX = (LOAD_CYCLES > GRACE_CYCLES) ? LOAD_CYCLES : GRACE_CYCLES;
  localparam int TMR_W = $clog2(TMR_MAX + 1);

  seq_state_e       state_q, state_d;
  logic             re_fall, re_rise, tmr_zero, tmr_load, adv;
  logic [TMR_W-1:0] tmr_val;
  logic [COL_W-1:0] col;
  logic             spare, last_col, last_in_blk;

  read_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (re_ni),
    .fall_o    (re_fall),
    .rise_o    (re_rise)
  );

  page_addr #(
    .PAGE_BYTES (PAGE_BYTES),
    .MAIN_BYTES (MAIN_BYTES),
    .BLK_PAGES  (BLK_PAGES),
    .PAGE_W     (PAGE_W)
  ) u_addr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .mode_i        (mode_i),
    .col_in_i      (start_col_i),
    .page_in_i     (start_page_i),
    .adv_i         (adv),
    .col_o         (col),
    .page_o        (rom_page_o),
    .spare_o       (spare),
    .last_col_o    (last_col),
    .last_in_blk_o (last_in_blk)
  );

  load_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign adv = (state_q == ST_READY) & re_rise & ~ce_ni;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(LOAD_CYCLES - 1);
    if (start_i) begin
      state_d  = ST_LOAD;
      tmr_load = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_LOAD:
          if (ce_ni)         state_d = ST_IDLE;
          else if (tmr_zero) state_d = ST_READY;
        ST_READY:
          if (ce_ni) state_d = ST_IDLE;
          else if (adv && last_col) begin
            if (last_in_blk) state_d = ST_IDLE;
            else begin
              state_d  = ST_GRACE;
              tmr_load = 1'b1;
              tmr_val  = TMR_W'(GRACE_CYCLES - 1);
            end
          end
        ST_GRACE:
          if (ce_ni) state_d = ST_IDLE;   // early CE rise drops the load
          else if (tmr_zero) begin
            state_d  = ST_LOAD;
            tmr_load = 1'b1;
          end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) re_err_o <= 1'b0;
    else         re_err_o <= re_fall & ~ce_ni & (state_q != ST_READY);

  assign rom_col_o = col;
  assign rb_o      = (state_q != ST_LOAD);
  assign dq_oe_o   = ~ce_ni & ~re_ni & ~cle_i & ~ale_i & (state_q == ST_READY);
  assign dq_o      = (col >= COL_W'(MAIN_BYTES)) ? {DATA_W{1'b1}} : rom_data_i;

  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col < COL_W'(PAGE_BYTES)); // R3
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !rb_o); // R2
  AST_SPARE_STAYS_SPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spare && state_q != ST_IDLE) |-> col >= COL_W'(MAIN_BYTES)); // R4
  AST_BLOCK_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(rom_page_o[PAGE_W-1:$clog2(BLK_PAGES)])); // R6
  AST_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_READY && !start_i) |=> $stable(col)); // R8
  AST_CE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !start_i) |=> state_q == ST_IDLE); // R10
endmodule

// File: tb/page_read_seq_tb.sv
module page_read_seq_tb;
  localparam int LOAD = 8;
  localparam int GRACE = 3;

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  col;
    logic [14:0] page;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 8'd5,   15'd100, 8'd3},   // R1 low half
    '{2'd1, 8'd250, 15'd7,   8'd10},  // R1 high half into spare, R5
    '{2'd2, 8'd13,  15'd40,  8'd5},   // R4 spare wrap, R7
    '{2'd1, 8'd255, 15'd2,   8'd20},  // R4 main wrap to column 0
    '{2'd3, 8'd3,   15'd8,   8'd4}    // R1 spare start, R5
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, ce_n = 1, re_n = 1, cle = 0, ale = 0;
  logic [1:0] mode = 0;
  logic [7:0] scol = 0;
  logic [14:0] spage = 0;
  logic [14:0] rom_page;
  logic [9:0] rom_col;
  logic [7:0] rom_data, dq;
  logic dq_oe, rb, re_err;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  page_read_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .start_col_i(scol), .start_page_i(spage), .ce_ni(ce_n), .re_ni(re_n),
    .cle_i(cle), .ale_i(ale), .rom_page_o(rom_page), .rom_col_o(rom_col),
    .rom_data_i(rom_data), .dq_o(dq), .dq_oe_o(dq_oe), .rb_o(rb), .re_err_o(re_err)
  );

  function automatic logic [7:0] rom_f(input int p, input int c);
    return 8'((p * 13 + c * 5 + (c >> 8)) & 255);
  endfunction

  function automatic logic [7:0] exp_byte(input int p, input int c);
    return (c >= 512) ? 8'hFF : rom_f(p, c);
  endfunction

  always_ff @(posedge clk) rom_data <= rom_f(int'(rom_page), int'(rom_col));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] m, input logic [7:0] c, input logic [14:0] p);
    @(negedge clk);
    ce_n = 0; mode = m; scol = c; spage = p; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (!rb && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_byte(output logic [7:0] d, output logic oe, output logic err);
    @(negedge clk);
    re_n = 0;
    @(negedge clk);
    d = dq; oe = dq_oe; err = re_err;
    re_n = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic count_low(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!rb) lows++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe, err;
    int nb, lows, gap;

    #12 rst_n = 1;
    @(negedge clk);
    check(rb == 1'b1, "R12 rb after reset", rb, 1);
    check(dq_oe == 1'b0, "R12 oe after reset", dq_oe, 0);
    check(re_err == 1'b0, "R12 err after reset", re_err, 0);

    // vector table
    for (int v = 0; v < 5; v++) begin
      int c, p;
      bit stop;
      p = int'(VECS[v].page);
      if (VECS[v].mode[1])      c = 512 + int'(VECS[v].col[3:0]);
      else if (VECS[v].mode[0]) c = 256 + int'(VECS[v].col);
      else                      c = int'(VECS[v].col);
      stop = 0;
      do_start(VECS[v].mode, VECS[v].col, VECS[v].page);
      count_busy(nb);
      check(nb == LOAD, "R2 start busy length", nb, LOAD);
      for (int k = 0; k < int'(VECS[v].n) && !stop; k++) begin
        read_byte(d, oe, err);
        check(d == exp_byte(p, c), (c >= 512) ? "R5 spare byte" : "R3 data byte (R1 start)",
              d, exp_byte(p, c));
        check(oe == 1'b1, "R11 oe while reading", oe, 1);
        if (c == 527) begin
          if ((p % 32) == 31) stop = 1;
          else begin
            p++;
            c = VECS[v].mode[1] ? 512 : 0;   // R4
            gap = 0;
            while (rb && gap < GRACE + 4) begin
              @(negedge clk);
              gap++;
            end
            check(!rb, "R7 busy at page crossing", rb, 0);
            count_busy(nb);
            check(nb == LOAD, "R7 crossing busy length", nb, LOAD);
          end
        end else c++;
      end
      @(negedge clk); ce_n = 1;
      @(negedge clk);
    end

    // R11: drive enable gated by cle/ale
    do_start(2'd0, 8'd10, 15'd5);
    count_busy(nb);
    @(negedge clk); re_n = 0; cle = 1;
    @(negedge clk);
    check(dq_oe == 1'b0, "R11 oe with cle high", dq_oe, 0);
    cle = 0; ale = 1;
    @(negedge clk);
    check(dq_oe == 1'b0, "R11 oe with ale high", dq_oe, 0);
    ale = 0;
    @(negedge clk);
    check(dq_oe == 1'b1 && dq == exp_byte(5, 10), "R11 oe and data when legal", dq, exp_byte(5, 10));
    re_n = 1;
    @(negedge clk); @(negedge clk);
    ce_n = 1;
    @(negedge clk);

    // R8: read pulse during busy flagged, no advance
    do_start(2'd0, 8'd20, 15'd6);
    re_n = 0;
    @(negedge clk);
    check(re_err == 1'b1, "R8 err during busy", re_err, 1);
    check(dq_oe == 1'b0, "R11 oe during busy", dq_oe, 0);
    re_n = 1;
    @(negedge clk);
    check(re_err == 1'b0, "R8 err is one cycle", re_err, 0);
    count_busy(nb);
    read_byte(d, oe, err);
    check(d == exp_byte(6, 20), "R8 column not advanced", d, exp_byte(6, 20));
    ce_n = 1;
    @(negedge clk);

    // R9: early CE rise after last byte drops the next load
    do_start(2'd0, 8'd254, 15'd9);   // low half: start col 254
    count_busy(nb);
    do_start(2'd2, 8'd15, 15'd9);    // spare: start at 527
    count_busy(nb);
    @(negedge clk); re_n = 0;
    @(negedge clk);
    check(dq == 8'hFF && dq_oe, "R5 last spare byte", dq, 8'hFF);
    re_n = 1;
    @(negedge clk); ce_n = 1;
    count_low(LOAD + GRACE + 8, lows);
    check(lows == 0, "R9 no busy after early CE", lows, 0);
    ce_n = 0;
    @(negedge clk); re_n = 0;
    @(negedge clk);
    check(re_err == 1'b1 && !dq_oe, "R9 idle after early CE", re_err, 1);
    re_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);

    // R10: CE abort mid-stream
    do_start(2'd0, 8'd0, 15'd12);
    count_busy(nb);
    read_byte(d, oe, err);
    read_byte(d, oe, err);
    check(d == exp_byte(12, 1), "R3 second byte", d, exp_byte(12, 1));
    ce_n = 1;
    @(negedge clk); @(negedge clk);
    ce_n = 0;
    @(negedge clk); re_n = 0;
    @(negedge clk);
    check(re_err == 1'b1, "R10 err after abort", re_err, 1);
    check(dq_oe == 1'b0, "R10 no drive after abort", dq_oe, 0);
    re_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);

    // R6: stop at block end
    do_start(2'd2, 8'd14, 15'd31);
    count_busy(nb);
    read_byte(d, oe, err);
    check(d == 8'hFF && oe, "R6 byte 526", d, 8'hFF);
    read_byte(d, oe, err);
    check(d == 8'hFF && oe, "R6 byte 527", d, 8'hFF);
    count_low(LOAD + GRACE + 8, lows);
    check(lows == 0, "R6 no busy at block end", lows, 0);
    @(negedge clk); re_n = 0;
    @(negedge clk);
    check(dq_oe == 1'b0, "R6 no data after block end", dq_oe, 0);
    check(re_err == 1'b1, "R6 err after block end", re_err, 1);
    re_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule